// File: doc/BRIEF.md
# Fixed-Period PWM Winding Current Chopper

This block regulates the current in one winding of a bipolar motor by commanding the state of its H-bridge. A free-running timer divides time into chopping periods of fixed length. At the start of each period the bridge is switched to drive, so the current rises. An external comparator raises a trip input when the sensed current reaches its target. The target is a reference voltage scaled by the indexer's current set-point. Once a trip is accepted, the bridge moves to a decay state and stays there until the next period begins. Trips are ignored during a leading-edge blanking window after each turn-on, so switching transients cannot end the drive phase early.

A tri-level decay select chooses the recirculation behaviour. Low gives slow decay and high gives fast decay. An undriven select gives mixed decay: fast decay for a fixed fraction of the remaining off time, then slow decay. The select arrives as a level bit and an "open" flag from the pad's detector. A zero set-point holds the bridge in slow decay for the whole period. A disable input switches every bridge transistor off and overrides all other states. When disable is released, a fresh full period begins.

The sense amplifier, reference DAC and comparator are outside this block. All control pins are plain levels. No data stream passes through the block, so it has no handshake.

Top module: `chop_current_regulator`

## Requirements
- R1: While reset is asserted, and through the first clock edge after its release, `bridge_cmd_o` is 2'b00 (all off). The first clock edge with reset released and disable low begins a period, which is cycle 0.
- R2: Every period lasts PERIOD_CYC cycles, numbered 0 to PERIOD_CYC-1. In cycle 0 the command is drive (2'b01) whenever the set-point sampled at the period boundary is nonzero.
- R3: A trip is accepted only when it is high in a drive cycle c with BLANK_CYC <= c <= PERIOD_CYC-2. The decay state then shows from cycle c+1. If no trip is accepted, drive holds to the end of the period.
- R4: With decay select 2'b00 (open flag 0, level 0), an accepted trip gives slow decay (2'b10) from cycle c+1 to the end of the period.
- R5: With decay select 2'b01 (open flag 0, level 1), an accepted trip gives fast decay (2'b11) from cycle c+1 to the end of the period.
- R6: With the open flag (bit 1) set, an accepted trip in cycle c gives fast decay for F = floor((PERIOD_CYC-1-c)*FAST_NUM / 2^FAST_SHIFT) cycles, then slow decay to the end of the period. When F is 0, slow decay follows directly.
- R7: A trip that is high only in the last cycle of a period has no effect. The next period begins in drive.
- R8: A zero set-point at a period boundary gives slow decay for that entire period, whatever the trip input does.
- R9: Disable high at a clock edge makes the command all-off in the following cycle, and this overrides every other state. The first edge after disable falls begins a new full period at cycle 0.
- R10: Once a decay state is entered, the trip input falling does not restore drive before the period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_i | input | 1 | Forces the bridge all-off and restarts the period timer |
| trip_i | input | 1 | Comparator output, high when winding current has reached its target |
| setpoint_i | input | SP_W | Indexer current set-point; only a value of zero changes the sequencing |
| decay_sel_i | input | 2 | Bit 1: select pin left open (mixed decay). Bit 0: select pin level (0 slow, 1 fast) |
| bridge_cmd_o | output | 2 | 00 all off, 01 drive, 10 slow decay, 11 fast decay |

## Verification
A wrong internal state in this block shows on `bridge_cmd_o` at the very next clock edge. Examples are a miscounted period, a blanking comparison that is off by one, or a mixed-decay split that is too long or too short. The command sequence of each period is a pure function of the trip cycle, the select and the set-point. A fault therefore appears as a single wrong code at a predictable cycle within one period, not as slow drift. Timer errors also shift the start of every later period, so they build up and show within one period of the fault.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    BR_OFF   = 2'b00,
    BR_DRIVE = 2'b01,
    BR_SLOW  = 2'b10,
    BR_FAST  = 2'b11
  } bridge_cmd_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10
  } decay_e;

  typedef enum logic [1:0] {
    PH_DRIVE = 2'b00,
    PH_FAST  = 2'b01,
    PH_SLOW  = 2'b10
  } phase_e;

  // Open-detect flag wins over the sampled level.
  function automatic decay_e decode_decay(input logic [1:0] sel);
    if (sel[1])      return DK_MIXED;
    else if (sel[0]) return DK_FAST;
    else             return DK_SLOW;
  endfunction

  function automatic bridge_cmd_e phase_to_cmd(input phase_e ph);
    case (ph)
      PH_DRIVE: return BR_DRIVE;
      PH_FAST:  return BR_FAST;
      default:  return BR_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD_CYC = 4167,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // Parked on the last count, so the next free edge opens cycle 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
    end else if (hold_i) begin
      cnt_q <= LAST;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == LAST);

endmodule

// File: rtl/chop_decay_decode.sv
module chop_decay_decode
  import chop_pkg::*;
(
  input  logic [1:0] sel_i,
  output decay_e     mode_o
);

  always_comb begin
    mode_o = decode_decay(sel_i);
  end

endmodule

// File: rtl/chop_fast_split.sv
module chop_fast_split #(
  parameter int PERIOD_CYC = 4167,
  parameter int FAST_NUM   = 3,
  parameter int FAST_SHIFT = 3,
  localparam int CNT_W  = $clog2(PERIOD_CYC),
  localparam int PROD_W = CNT_W + FAST_SHIFT + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] fast_len_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] remain;

  // Cycles left in the period after the trip cycle.
  assign remain = LAST - cnt_i;

  generate
    if (FAST_NUM == 0) begin : g_no_fast
      assign fast_len_o = '0;
    end else begin : g_scaled
      logic [PROD_W-1:0] prod;
      logic [PROD_W-1:0] shifted;
      assign prod       = PROD_W'(remain) * PROD_W'(FAST_NUM);
      assign shifted    = prod >> FAST_SHIFT;
      assign fast_len_o = shifted[CNT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 4167,
  parameter int BLANK_CYC  = 375,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disable_i,
  input  logic             wrap_i,
  input  logic             sp_zero_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  decay_e           mode_i,
  input  logic [CNT_W-1:0] fast_len_i,
  output bridge_cmd_e      cmd_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] fast_left_q;
  logic             mixed_q;
  logic             blank_done;
  logic             trip_take;

  assign blank_done = (int'(cnt_i) >= BLANK_CYC);
  assign trip_take  = trip_i && blank_done && (phase_q == PH_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_SLOW;
      fast_left_q <= '0;
      mixed_q     <= 1'b0;
    end else if (disable_i) begin
      phase_q     <= PH_SLOW;
      fast_left_q <= '0;
      mixed_q     <= 1'b0;
    end else if (wrap_i) begin
      // Period boundary outranks any trip in the last cycle.
      phase_q     <= sp_zero_i ? PH_SLOW : PH_DRIVE;
      fast_left_q <= '0;
      mixed_q     <= 1'b0;
    end else begin
      case (phase_q)
        PH_DRIVE: begin
          if (trip_take) begin
            case (mode_i)
              DK_FAST: phase_q <= PH_FAST;
              DK_MIXED: begin
                mixed_q     <= 1'b1;
                fast_left_q <= fast_len_i;
                phase_q     <= (fast_len_i == '0) ? PH_SLOW : PH_FAST;
              end
              default: phase_q <= PH_SLOW;
            endcase
          end
        end
        PH_FAST: begin
          if (mixed_q) begin
            if (fast_left_q <= 1) begin
              phase_q <= PH_SLOW;
            end
            if (fast_left_q != '0) begin
              fast_left_q <= fast_left_q - 1'b1;
            end
          end
        end
        default: phase_q <= PH_SLOW;
      endcase
    end
  end

  always_comb begin
    cmd_o = phase_to_cmd(phase_q);
  end

endmodule

// File: rtl/chop_current_regulator.sv
module chop_current_regulator
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 4167,
  parameter int BLANK_CYC  = 375,
  parameter int FAST_NUM   = 3,
  parameter int FAST_SHIFT = 3,
  parameter int SP_W       = 5,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disable_i,
  input  logic            trip_i,
  input  logic [SP_W-1:0] setpoint_i,
  input  logic [1:0]      decay_sel_i,
  output logic [1:0]      bridge_cmd_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  decay_e           mode;
  logic [CNT_W-1:0] fast_len;
  bridge_cmd_e      phase_cmd;
  logic             off_q;

  chop_period_timer #(
    .PERIOD_CYC(PERIOD_CYC)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (disable_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  chop_decay_decode decode_i (
    .sel_i  (decay_sel_i),
    .mode_o (mode)
  );

  chop_fast_split #(
    .PERIOD_CYC (PERIOD_CYC),
    .FAST_NUM   (FAST_NUM),
    .FAST_SHIFT (FAST_SHIFT)
  ) split_i (
    .cnt_i      (cnt_q),
    .fast_len_o (fast_len)
  );

  chop_phase_fsm #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disable_i  (disable_i),
    .wrap_i     (wrap),
    .sp_zero_i  (setpoint_i == '0),
    .trip_i     (trip_i),
    .cnt_i      (cnt_q),
    .mode_i     (mode),
    .fast_len_i (fast_len),
    .cmd_o      (phase_cmd)
  );

  // Registered all-off override, set from reset until the first free edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b1;
    else        off_q <= disable_i;
  end

  assign bridge_cmd_o = off_q ? BR_OFF : phase_cmd;

endmodule

// File: rtl/chop_current_regulator_chk.sv
module chop_current_regulator_chk #(
  parameter int PERIOD_CYC = 4167,
  parameter int BLANK_CYC  = 375,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disable_i,
  input logic [1:0]       cmd_i,
  input logic [CNT_W-1:0] cnt_i
);

  logic at_last;
  assign at_last = (int'(cnt_i) == PERIOD_CYC - 1);

  a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (cmd_i == 2'b00));

  a_r9_enabled_not_off: assert property (@(posedge clk) disable iff (!rst_n)
    !disable_i |=> (cmd_i != 2'b00));

  a_r3_blank_holds_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b01 && int'(cnt_i) < BLANK_CYC && !at_last && !disable_i)
      |=> (cmd_i == 2'b01));

  a_r2_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !disable_i) |=> (cmd_i == 2'b01 || cmd_i == 2'b10));

  a_r10_no_redrive: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != 2'b01 && !at_last) |=> (cmd_i != 2'b01));

  a_r6_slow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b10 && !at_last && !disable_i) |=> (cmd_i == 2'b10));

endmodule

bind chop_current_regulator chop_current_regulator_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .BLANK_CYC  (BLANK_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .disable_i (disable_i),
  .cmd_i     (bridge_cmd_o),
  .cnt_i     (cnt_q)
);

// File: tb/chop_current_regulator_tb_top.sv
module chop_current_regulator_tb_top;

  localparam int P     = 20;
  localparam int BLANK = 4;
  localparam int NUM   = 3;
  localparam int SH    = 3;
  localparam int SP_W  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dis = 1'b0;
  logic            trip = 1'b0;
  logic [SP_W-1:0] sp = SP_W'(5);
  logic [1:0]      dec = 2'b00;
  logic [1:0]      cmd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chop_current_regulator #(
    .PERIOD_CYC (P),
    .BLANK_CYC  (BLANK),
    .FAST_NUM   (NUM),
    .FAST_SHIFT (SH),
    .SP_W       (SP_W)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .disable_i    (dis),
    .trip_i       (trip),
    .setpoint_i   (sp),
    .decay_sel_i  (dec),
    .bridge_cmd_o (cmd)
  );

  task automatic check(input string req, input logic [1:0] exp_v, input int k);
    checks++;
    if (cmd !== exp_v) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", req, k, cmd, exp_v);
    end
  endtask

  // Starts at the negedge of the cycle before a period boundary.
  task automatic run_period(input logic [1:0] sel, input bit sp0,
                            input int trip_at, input int trip_len);
    int t0;
    bit hit;
    int fl;
    logic [1:0] e;
    string req;
    dec = sel;
    sp  = sp0 ? '0 : SP_W'(5);
    @(posedge clk);
    t0  = (trip_at > BLANK) ? trip_at : BLANK;
    hit = !sp0 && (t0 < trip_at + trip_len) && (t0 <= P - 2);
    fl  = ((P - 1 - t0) * NUM) >> SH;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (sp0) begin
        e = 2'b10; req = "R8";
      end else if (!hit || k <= t0) begin
        e = 2'b01;
        req = (k == 0) ? "R2" : ((trip_at == P - 1) ? "R7" : "R3");
      end else if (sel[1]) begin
        e = (k <= t0 + fl) ? 2'b11 : 2'b10; req = "R6";
      end else if (sel[0]) begin
        e = 2'b11; req = (trip_len == 1) ? "R10" : "R5";
      end else begin
        e = 2'b10; req = (trip_len == 1) ? "R10" : "R4";
      end
      check(req, e, k);
      trip = (k >= trip_at) && (k < trip_at + trip_len);
    end
  endtask

  initial begin
    int trips [10];
    logic [1:0] sels [4];
    trips = '{0, 2, BLANK - 1, BLANK, BLANK + 1, 10, P - 4, P - 3, P - 2, P - 1};
    sels  = '{2'b00, 2'b01, 2'b10, 2'b11};
    repeat (3) @(negedge clk);
    check("R1", 2'b00, -1);
    rst_n = 1'b1;
    check("R1", 2'b00, -1);

    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 10; t++) begin
        run_period(sels[m], 1'b0, trips[t], 100);
        run_period(sels[m], 1'b0, trips[t], 1);
      end
    end
    run_period(2'b01, 1'b0, P, 0);
    run_period(2'b01, 1'b1, 0, 100);
    run_period(2'b10, 1'b1, BLANK, 3);

    // R9: disable at a boundary, with trip high, then restart.
    dis = 1'b1; trip = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9", 2'b00, k);
    end
    dis = 1'b0; trip = 1'b0;
    run_period(2'b10, 1'b0, 6, 100);

    // R9: disable in the middle of a fast-decay period.
    dec = 2'b01; sp = SP_W'(5); trip = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9", (k <= BLANK + 1) ? 2'b01 : 2'b11, k);
      trip = (k >= BLANK + 1);
    end
    dis = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9", 2'b00, k);
    end
    dis = 1'b0;
    run_period(2'b00, 1'b0, BLANK, 100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule